// File: doc/BRIEF.md
# Write-One Pulse GPIO Bank

This block is a bank of up to eight general-purpose pins driven from a single 32-bit register port. A write does not store its word. Each bit written as 1 requests one action on one pin, and each bit written as 0 requests nothing. Several software agents can therefore change different pins without a read-modify-write sequence and without a lock, because a write only touches the pins whose action bits it sets.

Each pin n owns two adjacent action bits in the low half-word and two in the high half-word. The low pair controls the pin's output latch: bit 2n drives it to 0 and bit 2n+1 drives it to 1. The high pair controls the pin's direction: bit 16+2n turns the output driver on and bit 17+2n turns it off. A read returns the level of pin n on bit 2n+1. For an output pin that level is the output latch. For an input pin it is the pad value after a two-flop synchronizer.

The usual way to make a pin an output without a glitch is to write the wanted level while the pin is still an input, then write the direction bit. Two banks of the same design are used side by side, one with eight pins and one with four.

Top module: `gpio_pulse_bank`

## Requirements
- R1: While reset is asserted and just after it, every pin is an input (pad_oe all 0), every output latch is 0, and rdata is 0.
- R2: On a cycle with wr_en high, for a pin n below PINS, wdata[2n]=1 with wdata[2n+1]=0 makes pad_out[n] 0 from the next clock edge. wdata[2n+1]=1 with wdata[2n]=0 makes it 1.
- R3: A write that sets both wdata[2n] and wdata[2n+1] leaves pad_out[n] at its previous value.
- R4: On a write, wdata[16+2n]=1 alone sets pad_oe[n] to 1 and wdata[17+2n]=1 alone clears it. Both set together leaves pad_oe[n] unchanged.
- R5: Action bits written as 0 change nothing. A cycle with wr_en low changes no pad_out or pad_oe bit, whatever wdata holds.
- R6: rdata[2n+1] equals pad_out[n] when pad_oe[n] is 1. Otherwise it equals the value pad_in[n] had two clock edges earlier (two-flop synchronizer).
- R7: rdata bits 2n, all bits from 16 up, and the read bits of pins at or above PINS are always 0. Action bits of pins at or above PINS are ignored.
- R8: The output latch can be written while the pin is an input, with pad_out following the write. Enabling the driver afterwards presents that level, and level and direction action bits in the same write both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe for one cycle |
| wdata | input | 32 | Action word, one request per 1 bit |
| rdata | output | 32 | Pin levels on the odd bits of the low half-word |
| pad_out | output | PINS | Output latch value per pin |
| pad_oe | output | PINS | Output driver enable per pin |
| pad_in | input | PINS | Pad input level per pin |

## Verification
The hardest case to reach is a write carrying conflicting requests: both level bits or both direction bits of one pin, mixed with single requests for neighbouring pins in the same word. Random words hit that only rarely when they are sparse. The stimulus therefore draws dense words in which every bit pair has an even chance of being 00, 01, 10 or 11. Directed writes cover each conflict on its own. The input-path latency is isolated by toggling pad_in on pins that are inputs and checking the readback one edge and then two edges later. A second four-pin instance receives the same words, so that action bits for absent pins are exercised against a bank where they must be ignored.

// File: rtl/gpio_pulse_bank.sv
module gpio_pulse_bank #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  input  logic [PINS-1:0] pad_in
);

  localparam int DIR_BASE = 16;

  logic [PINS-1:0] meta_q, sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    wire lo  = wr_en & wdata[2*n];
    wire hi  = wr_en & wdata[2*n+1];
    wire drv = wr_en & wdata[DIR_BASE+2*n];
    wire rel = wr_en & wdata[DIR_BASE+2*n+1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pad_out[n] <= 1'b0;
        pad_oe[n]  <= 1'b0;
      end else begin
        if (lo ^ hi)   pad_out[n] <= hi;
        if (drv ^ rel) pad_oe[n]  <= drv;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int n = 0; n < PINS; n++)
      rdata[2*n+1] = pad_oe[n] ? pad_out[n] : sync_q[n];
  end

endmodule

module gpio_pulse_bank_chk #(
  parameter int PINS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [31:0]     wdata,
  input logic [31:0]     rdata,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pad_oe
);

  logic [PINS-1:0] lo_only, hi_only, lv_both, drv_only, rel_only, dir_both, rd_lvl;
  logic [31:0]     rd_mask;

  always_comb begin
    rd_mask = '0;
    for (int n = 0; n < PINS; n++) begin
      lo_only[n]  = wdata[2*n] & ~wdata[2*n+1];
      hi_only[n]  = wdata[2*n+1] & ~wdata[2*n];
      lv_both[n]  = wdata[2*n] & wdata[2*n+1];
      drv_only[n] = wdata[16+2*n] & ~wdata[17+2*n];
      rel_only[n] = wdata[17+2*n] & ~wdata[16+2*n];
      dir_both[n] = wdata[16+2*n] & wdata[17+2*n];
      rd_lvl[n]   = rdata[2*n+1];
      rd_mask[2*n+1] = 1'b1;
    end
  end

  a_r2_drive_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (lo_only != 0) |=> (pad_out & $past(lo_only)) == 0);

  a_r2_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (hi_only != 0) |=> (pad_out & $past(hi_only)) == $past(hi_only));

  a_r3_conflict_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (lv_both != 0) |=> ((pad_out ^ $past(pad_out)) & $past(lv_both)) == 0);

  a_r4_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (drv_only != 0) |=> (pad_oe & $past(drv_only)) == $past(drv_only));

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (rel_only != 0) |=> (pad_oe & $past(rel_only)) == 0);

  a_r4_conflict_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (dir_both != 0) |=> ((pad_oe ^ $past(pad_oe)) & $past(dir_both)) == 0);

  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pad_out) && $stable(pad_oe));

  a_r6_output_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lvl & pad_oe) == (pad_out & pad_oe));

  a_r7_unused_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~rd_mask) == 0);

endmodule

bind gpio_pulse_bank gpio_pulse_bank_chk #(.PINS(PINS)) u_chk (.*);

// File: tb/sim_gpio_pulse_bank.sv
`timescale 1ns/1ps
module sim_gpio_pulse_bank;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [7:0]  pad_in = '0;
  logic [31:0] rdata, rdata4;
  logic [7:0]  pad_out, pad_oe;
  logic [3:0]  pad_out4, pad_oe4;

  always #5 clk = ~clk;

  gpio_pulse_bank #(.PINS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in));

  gpio_pulse_bank #(.PINS(4)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata4),
    .pad_out(pad_out4), .pad_oe(pad_oe4), .pad_in(pad_in[3:0]));

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  bit m_out[8];
  bit m_oe[8];
  bit m_s1[8];
  bit m_s2[8];

  function automatic logic [31:0] exp_rd(int npins);
    logic [31:0] r = '0;
    for (int n = 0; n < npins; n++) r[2*n+1] = m_oe[n] ? m_out[n] : m_s2[n];
    return r;
  endfunction

  function automatic logic [7:0] exp_vec(bit which);
    logic [7:0] v;
    for (int n = 0; n < 8; n++) v[n] = which ? m_oe[n] : m_out[n];
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2/R3 pad_out", {24'd0, pad_out}, {24'd0, exp_vec(1'b0)});
    check("R4 pad_oe", {24'd0, pad_oe}, {24'd0, exp_vec(1'b1)});
    check("R6 rdata", rdata, exp_rd(8));
    check("R7 four-pin pad_out", {28'd0, pad_out4}, {28'd0, exp_vec(1'b0)} & 32'hF);
    check("R7 four-pin pad_oe", {28'd0, pad_oe4}, {28'd0, exp_vec(1'b1)} & 32'hF);
    check("R7 four-pin rdata", rdata4, exp_rd(4));
  endtask

  task automatic cyc(bit we, logic [31:0] wd, logic [7:0] pin);
    wr_en = we;
    wdata = wd;
    pad_in = pin;
    @(posedge clk);
    if (!rst_n) begin
      for (int n = 0; n < 8; n++) begin
        m_out[n] = 0; m_oe[n] = 0; m_s1[n] = 0; m_s2[n] = 0;
      end
    end else begin
      for (int n = 0; n < 8; n++) begin
        m_s2[n] = m_s1[n];
        m_s1[n] = pin[n];
        if (we) begin
          if (wd[2*n] && !wd[2*n+1]) m_out[n] = 0;
          if (wd[2*n+1] && !wd[2*n]) m_out[n] = 1;
          if (wd[16+2*n] && !wd[17+2*n]) m_oe[n] = 1;
          if (wd[17+2*n] && !wd[16+2*n]) m_oe[n] = 0;
        end
      end
    end
    #1;
    compare_all();
  endtask

  function automatic logic [31:0] dense_word();
    logic [31:0] w;
    w = $urandom;
    return w;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 8; n++) begin
      m_out[n] = 0; m_oe[n] = 0; m_s1[n] = 0; m_s2[n] = 0;
    end
    rst_n = 1'b0;
    cyc(1'b1, 32'hFFFF_FFFF, 8'hFF);
    cyc(1'b0, 32'h0, 8'hFF);
    check("R1 reset oe", {24'd0, pad_oe}, 32'd0);
    check("R1 reset out", {24'd0, pad_out}, 32'd0);
    check("R1 reset rdata", rdata, 32'd0);
    rst_n = 1'b1;
    cyc(1'b0, 32'h0, 8'h00);
    check("R1 after reset rdata", rdata, 32'd0);

    cyc(1'b1, 32'h0000_0002, 8'h00);
    check("R2 pin0 high", {31'd0, pad_out[0]}, 32'd1);
    cyc(1'b1, 32'h0000_0001, 8'h00);
    check("R2 pin0 low", {31'd0, pad_out[0]}, 32'd0);
    cyc(1'b1, 32'h0000_0008, 8'h00);
    cyc(1'b1, 32'h0000_000C, 8'h00);
    check("R3 both level bits hold high", {31'd0, pad_out[1]}, 32'd1);
    cyc(1'b1, 32'h0000_0030, 8'h00);
    check("R3 both level bits hold low", {31'd0, pad_out[2]}, 32'd0);

    cyc(1'b1, 32'h0001_0000, 8'h00);
    check("R4 pin0 enabled", {31'd0, pad_oe[0]}, 32'd1);
    cyc(1'b1, 32'h0003_0000, 8'h00);
    check("R4 both dir bits hold", {31'd0, pad_oe[0]}, 32'd1);
    cyc(1'b1, 32'h0002_0000, 8'h00);
    check("R4 pin0 released", {31'd0, pad_oe[0]}, 32'd0);

    cyc(1'b0, 32'hFFFF_FFFF, 8'h00);
    check("R5 idle keeps pad_out", {24'd0, pad_out}, 32'h02);
    check("R5 idle keeps pad_oe", {24'd0, pad_oe}, 32'h00);
    cyc(1'b1, 32'h0000_0000, 8'h00);
    check("R5 zero word keeps pad_out", {24'd0, pad_out}, 32'h02);

    cyc(1'b1, 32'h0000_8000, 8'h00);
    check("R8 latch set while input", {31'd0, pad_out[7]}, 32'd1);
    check("R8 pin7 still input", {31'd0, pad_oe[7]}, 32'd0);
    cyc(1'b1, 32'h4000_0000, 8'h00);
    check("R8 pin7 drives preset level", {31'd0, rdata[15]}, 32'd1);
    cyc(1'b1, 32'h0004_0001, 8'h00);
    check("R8 same-word level and dir", {30'd0, pad_oe[1], pad_out[0]}, 32'd2);

    cyc(1'b1, 32'hAAAA_0000, 8'h00);
    cyc(1'b0, 32'h0, 8'h20);
    check("R6 one edge: not yet seen", {31'd0, rdata[11]}, 32'd0);
    cyc(1'b0, 32'h0, 8'h20);
    check("R6 two edges: seen", {31'd0, rdata[11]}, 32'd1);
    check("R7 even and high bits zero", rdata & 32'hFFFF_5555, 32'd0);
    check("R7 four-pin upper read bits zero", rdata4 & 32'hFFFF_FF00, 32'd0);

    for (int i = 0; i < 400; i++)
      cyc(($urandom % 4) != 0, dense_word(), 8'($urandom));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule